// File: doc/BRIEF.md
# Basic-Rate ISDN Frame Bit Router

This block sits on a basic-rate ISDN interchip serial bus and decides, one bit time at a time, where each bit belongs. It runs on the bus bit clock. A one-bit-time sync pulse fixes the frame position, and the block counts the bit positions of the frame after it. A frame holds 18 data bits: the two 8-bit bearer channels B1 and B2 and the two single-bit signalling channels D1 and D2. A configuration input picks one of two frame layouts. Both layouts carry the same four channels, and only the channel order differs.

Two route tables, one for receive and one for transmit, hold one entry per logical channel bit. Each entry has an enable, a 2-bit destination index and a strobe flag. A received bit whose entry is enabled goes to one of four internal serial channels, together with its destination index. A bit whose entry has the strobe flag set raises a strobe for an external device instead. On transmit, the table picks which channel supplies the bit in each bit time. In bit times that have no route, the data line is left undriven. Because routing works on single bits, a channel can take fewer than 8 bits of a bearer channel per frame, which is what sub-rate adaptation needs.

Top module: `bri_bit_router`

## Requirements
- R1: While reset is asserted and after it is released, `rx_valid`, `rx_strobe`, `tx_strobe`, `bus_txd_en` and every bit of `tx_take` are low.
- R2: `bus_sync` high during one bit time makes the next bit time frame position 0. Each later bit time advances the position by one, up to 17. Bit times after position 17 are idle until the next sync. A sync seen in the middle of a frame restarts the count from 0 in the following bit time.
- R3: Route entries are indexed by logical slot: B1 bit i is slot i, B2 bit i is slot 8+i, D1 is slot 16 and D2 is slot 17. When `fmt_10bit`=0, frame positions 0-7 carry B1, 8 carries D1, 9-16 carry B2 and 17 carries D2. When `fmt_10bit`=1, positions 0-7 carry B1, 8 carries D1, 9 carries D2 and 10-17 carry B2.
- R4: `bus_rxd` is sampled on the falling clock edge. For a frame bit whose receive entry has enable=1 and strobe=0, the next rising edge sets `rx_valid` high for one cycle, with `rx_bit` equal to the sampled value and `rx_dest` equal to the entry's destination.
- R5: A received frame bit whose receive entry has enable=0, or a bit received in an idle bit time, leaves `rx_valid` and `rx_strobe` low.
- R6: A received frame bit whose receive entry has enable=1 and strobe=1 raises `rx_strobe` for one cycle, at the timing of R4, and leaves `rx_valid` low.
- R7: For a frame position whose transmit entry has enable=1 and strobe=0, the rising edge that opens that bit time sets `bus_txd_en` high and `bus_txd` to `ch_tx_bit[dest]` as sampled at that edge. During that bit time `tx_take` is one-hot at bit `dest`.
- R8: In a bit time whose transmit entry has enable=0, and in every idle bit time, `bus_txd_en` is low, `bus_txd` is high impedance and `tx_take` is zero.
- R9: For a frame position whose transmit entry has enable=1 and strobe=1, `tx_strobe` is high for that bit time and the data line stays undriven.
- R10: From reset until the first sync, no received bit is routed and the data line is not driven, whatever the route tables hold.
- R11: A rising edge with `cfg_we`=1 writes the entry {`cfg_en`, `cfg_strb`, `cfg_dest`} at slot `cfg_slot`. It writes the transmit table when `cfg_tx`=1 and the receive table otherwise. Both tables reset to all-disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_10bit | input | 1 | Frame layout select: 0 = 8-bit order, 1 = 10-bit order |
| bus_sync | input | 1 | Frame sync, high for the bit time before position 0 |
| bus_rxd | input | 1 | Serial receive data |
| bus_txd | output | 1 | Serial transmit data, high impedance when not driven |
| bus_txd_en | output | 1 | Transmit drive enable for a pad cell |
| cfg_we | input | 1 | Route entry write strobe |
| cfg_tx | input | 1 | Table select: 1 = transmit, 0 = receive |
| cfg_slot | input | 5 | Logical slot being written |
| cfg_en | input | 1 | Entry enable |
| cfg_strb | input | 1 | Entry strobe flag |
| cfg_dest | input | 2 | Entry destination channel index |
| rx_valid | output | 1 | Routed receive bit present |
| rx_bit | output | 1 | Routed receive bit value |
| rx_dest | output | 2 | Destination channel of the routed bit |
| rx_strobe | output | 1 | Receive-side external strobe |
| ch_tx_bit | input | 4 | Next transmit bit offered by each channel |
| tx_take | output | 4 | One-hot: the channel whose bit is on the line |
| tx_strobe | output | 1 | Transmit-side external strobe |

## Verification
With every slot enabled and the destinations spread across the channels, the bench runs the same receive pattern and the same tables under both layouts. Only the channel order separates the two results, so a wrong position-to-slot mapping shows up directly. A sparse table then enables only two B1 bits and D2 and puts strobes on D1 and all of B2. This separates enabled bits from disabled and strobed ones, and shows a sub-rate channel collecting two bits per frame. Another run sends a sync partway through a frame, which shows the count restarting. A run with no sync after reset, with the tables full, shows that nothing is routed before alignment.

// File: rtl/bri_router_pkg.sv
package bri_router_pkg;

  localparam int DEST_W = 2;
  localparam int NUM_CH = 1 << DEST_W;

  typedef struct packed {
    logic              en;
    logic              strb;
    logic [DEST_W-1:0] dest;
  } route_entry_t;

  // Map a frame position to a logical slot (B1: 0..bb-1, B2: bb..2bb-1,
  // D1: 2bb, D2: 2bb+1) for the selected layout.
  function automatic int unsigned slot_of_pos(input logic fmt10,
                                              input int unsigned pos,
                                              input int unsigned bb);
    int unsigned s;
    if (pos < bb)            s = pos;
    else if (pos == bb)      s = 2 * bb;
    else if (fmt10)          s = (pos == bb + 1) ? 2 * bb + 1 : pos - 2;
    else                     s = (pos == 2 * bb + 1) ? 2 * bb + 1 : pos - 1;
    return s;
  endfunction

  function automatic logic pos_in_frame(input int unsigned pos,
                                        input int unsigned bb);
    return pos < 2 * bb + 2;
  endfunction

endpackage

// File: rtl/bri_frame_timer.sv
module bri_frame_timer #(
  parameter int B_BITS     = 8,
  parameter int FRAME_BITS = 2 * B_BITS + 2,
  parameter int POS_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sync,
  input  logic             bus_rxd,
  output logic [POS_W-1:0] pos_now,
  output logic [POS_W-1:0] pos_next,
  output logic             rxd_smp,
  output logic             sync_smp
);

  localparam logic [POS_W-1:0] IDLE = POS_W'(FRAME_BITS);

  logic [POS_W-1:0] pos_q;

  // Bus inputs are sampled in the middle of the bit time.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_smp  <= 1'b0;
      sync_smp <= 1'b0;
    end else begin
      rxd_smp  <= bus_rxd;
      sync_smp <= bus_sync;
    end
  end

  always_comb begin
    if (sync_smp)           pos_next = '0;
    else if (pos_q == IDLE) pos_next = IDLE;
    else                    pos_next = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= IDLE;
    else        pos_q <= pos_next;
  end

  assign pos_now = pos_q;

  AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_smp |=> (pos_q == '0)); // R2

  AST_POS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_smp && pos_q < IDLE) |=> (pos_q == $past(pos_q) + 1'b1)); // R2

endmodule

// File: rtl/bri_route_table.sv
module bri_route_table
  import bri_router_pkg::*;
#(
  parameter int DEPTH = 18,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  route_entry_t wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output route_entry_t rd_data
);

  route_entry_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

endmodule

// File: rtl/bri_rx_path.sv
module bri_rx_path
  import bri_router_pkg::*;
#(
  parameter int B_BITS     = 8,
  parameter int FRAME_BITS = 2 * B_BITS + 2,
  parameter int POS_W      = $clog2(FRAME_BITS + 1),
  parameter int SLOT_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt10,
  input  logic [POS_W-1:0]  pos_now,
  input  logic              rxd_smp,
  output logic [SLOT_W-1:0] rd_slot,
  input  route_entry_t      ent,
  output logic              rx_valid,
  output logic              rx_bit,
  output logic [DEST_W-1:0] rx_dest,
  output logic              rx_strobe
);

  logic in_frame, deliver, strobe_hit;

  assign in_frame   = pos_in_frame(int'(pos_now), B_BITS);
  assign rd_slot    = in_frame ? SLOT_W'(slot_of_pos(fmt10, int'(pos_now), B_BITS)) : '0;
  assign deliver    = in_frame && ent.en && !ent.strb;
  assign strobe_hit = in_frame && ent.en && ent.strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b0;
      rx_dest   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_valid  <= deliver;
      rx_bit    <= deliver & rxd_smp;
      rx_dest   <= deliver ? ent.dest : '0;
      rx_strobe <= strobe_hit;
    end
  end

  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_strobe)); // R6

endmodule

// File: rtl/bri_tx_path.sv
module bri_tx_path
  import bri_router_pkg::*;
#(
  parameter int B_BITS     = 8,
  parameter int FRAME_BITS = 2 * B_BITS + 2,
  parameter int POS_W      = $clog2(FRAME_BITS + 1),
  parameter int SLOT_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt10,
  input  logic [POS_W-1:0]  pos_next,
  input  logic [NUM_CH-1:0] ch_tx_bit,
  output logic [SLOT_W-1:0] rd_slot,
  input  route_entry_t      ent,
  output logic              tx_oe,
  output logic              tx_d,
  output logic [NUM_CH-1:0] tx_take,
  output logic              tx_strobe
);

  logic              in_frame, drive, strobe_hit;
  logic [NUM_CH-1:0] take_n;

  assign in_frame   = pos_in_frame(int'(pos_next), B_BITS);
  assign rd_slot    = in_frame ? SLOT_W'(slot_of_pos(fmt10, int'(pos_next), B_BITS)) : '0;
  assign drive      = in_frame && ent.en && !ent.strb;
  assign strobe_hit = in_frame && ent.en && ent.strb;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_take
    assign take_n[c] = drive && (int'(ent.dest) == c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_oe     <= 1'b0;
      tx_d      <= 1'b0;
      tx_take   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_oe     <= drive;
      tx_d      <= drive & ch_tx_bit[ent.dest];
      tx_take   <= take_n;
      tx_strobe <= strobe_hit;
    end
  end

  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_take)); // R7

endmodule

// File: rtl/bri_bit_router.sv
module bri_bit_router
  import bri_router_pkg::*;
#(
  parameter int B_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_10bit,
  input  logic        bus_sync,
  input  logic        bus_rxd,
  output logic        bus_txd,
  output logic        bus_txd_en,
  input  logic        cfg_we,
  input  logic        cfg_tx,
  input  logic [4:0]  cfg_slot,
  input  logic        cfg_en,
  input  logic        cfg_strb,
  input  logic [1:0]  cfg_dest,
  output logic        rx_valid,
  output logic        rx_bit,
  output logic [1:0]  rx_dest,
  output logic        rx_strobe,
  input  logic [3:0]  ch_tx_bit,
  output logic [3:0]  tx_take,
  output logic        tx_strobe
);

  localparam int FRAME_BITS = 2 * B_BITS + 2;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);
  localparam int SLOT_W     = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] IDLE = POS_W'(FRAME_BITS);

  logic [POS_W-1:0]  pos_now, pos_next;
  logic              rxd_smp, sync_smp;
  logic [SLOT_W-1:0] rx_slot, tx_slot, wr_slot;
  route_entry_t      rx_ent, tx_ent, wr_ent;
  logic              tx_d;

  assign wr_slot = SLOT_W'(cfg_slot);
  assign wr_ent  = '{en: cfg_en, strb: cfg_strb, dest: cfg_dest};

  bri_frame_timer #(.B_BITS(B_BITS)) timer_i (
    .clk(clk), .rst_n(rst_n), .bus_sync(bus_sync), .bus_rxd(bus_rxd),
    .pos_now(pos_now), .pos_next(pos_next),
    .rxd_smp(rxd_smp), .sync_smp(sync_smp)
  );

  bri_route_table #(.DEPTH(FRAME_BITS), .IDX_W(SLOT_W)) rx_tab_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && !cfg_tx), .wr_idx(wr_slot),
    .wr_data(wr_ent), .rd_idx(rx_slot), .rd_data(rx_ent)
  );

  bri_route_table #(.DEPTH(FRAME_BITS), .IDX_W(SLOT_W)) tx_tab_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && cfg_tx), .wr_idx(wr_slot),
    .wr_data(wr_ent), .rd_idx(tx_slot), .rd_data(tx_ent)
  );

  bri_rx_path #(.B_BITS(B_BITS)) rx_i (
    .clk(clk), .rst_n(rst_n), .fmt10(fmt_10bit), .pos_now(pos_now),
    .rxd_smp(rxd_smp), .rd_slot(rx_slot), .ent(rx_ent),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_dest(rx_dest), .rx_strobe(rx_strobe)
  );

  bri_tx_path #(.B_BITS(B_BITS)) tx_i (
    .clk(clk), .rst_n(rst_n), .fmt10(fmt_10bit), .pos_next(pos_next),
    .ch_tx_bit(ch_tx_bit), .rd_slot(tx_slot), .ent(tx_ent),
    .tx_oe(bus_txd_en), .tx_d(tx_d), .tx_take(tx_take), .tx_strobe(tx_strobe)
  );

  assign bus_txd = bus_txd_en ? tx_d : 1'bz;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_now == IDLE) |-> !bus_txd_en); // R8

  AST_STROBE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> !bus_txd_en); // R9

  AST_RX_FROM_FRAME_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || rx_strobe) |-> ($past(pos_now) < IDLE)); // R4

  AST_SYNC_QUIET_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!sync_smp) && $past(pos_now) == IDLE) |-> !rx_valid); // R10

endmodule

// File: tb/bri_bit_router_tb_top.sv
`timescale 1ns/1ps
module bri_bit_router_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fmt_10bit, bus_sync, bus_rxd;
  wire        bus_txd;
  logic       bus_txd_en;
  logic       cfg_we, cfg_tx, cfg_en, cfg_strb;
  logic [4:0] cfg_slot;
  logic [1:0] cfg_dest;
  logic       rx_valid, rx_bit, rx_strobe;
  logic [1:0] rx_dest;
  logic [3:0] ch_tx_bit, tx_take;
  logic       tx_strobe;

  int n_total = 0;
  int n_pass  = 0;
  bit done    = 0;

  // bench-side route model
  bit       m_rx_en [18];
  bit       m_rx_sb [18];
  bit [1:0] m_rx_ds [18];
  bit       m_tx_en [18];
  bit       m_tx_sb [18];
  bit [1:0] m_tx_ds [18];

  always #2 clk = ~clk;

  bri_bit_router dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_10bit(fmt_10bit), .bus_sync(bus_sync),
    .bus_rxd(bus_rxd), .bus_txd(bus_txd), .bus_txd_en(bus_txd_en),
    .cfg_we(cfg_we), .cfg_tx(cfg_tx), .cfg_slot(cfg_slot), .cfg_en(cfg_en),
    .cfg_strb(cfg_strb), .cfg_dest(cfg_dest), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rx_dest(rx_dest), .rx_strobe(rx_strobe),
    .ch_tx_bit(ch_tx_bit), .tx_take(tx_take), .tx_strobe(tx_strobe)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act == exp) n_pass++;
    else $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  // Layout table written as explicit ranges per R3
  function automatic int slot_for(input bit fmt10, input int p);
    if (!fmt10) begin
      case (p) inside
        [0:7]:   return p;
        8:       return 16;
        [9:16]:  return p - 1;
        default: return 17;
      endcase
    end else begin
      case (p) inside
        [0:7]:   return p;
        8:       return 16;
        9:       return 17;
        default: return p - 2;
      endcase
    end
  endfunction

  task automatic wr(input bit tx, input int slot, input bit en, input bit sb, input bit [1:0] ds);
    if (tx) begin m_tx_en[slot] = en; m_tx_sb[slot] = sb; m_tx_ds[slot] = ds; end
    else    begin m_rx_en[slot] = en; m_rx_sb[slot] = sb; m_rx_ds[slot] = ds; end
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_tx = tx; cfg_slot = 5'(slot); cfg_en = en; cfg_strb = sb; cfg_dest = ds;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic check_quiet(input string req);
    check_eq(req, "rx_valid", int'(rx_valid), 0);
    check_eq(req, "rx_strobe", int'(rx_strobe), 0);
    check_eq(req, "bus_txd_en", int'(bus_txd_en), 0);
    check_eq(req, "tx_take", int'(tx_take), 0);
    check_eq(req, "tx_strobe", int'(tx_strobe), 0);
  endtask

  // One frame: sync bit, 18 data bits, one idle bit.
  task automatic run_frame(input bit fmt10, input bit [17:0] pat, input bit [3:0] chd,
                           input bit skip_head, input string tag);
    fmt_10bit = fmt10;
    for (int j = 0; j < 20; j++) begin
      @(posedge clk); #1;
      if (!(skip_head && j == 0)) begin
        if (j >= 1 && j <= 18) begin
          int s = slot_for(fmt10, j - 1);
          bit hit = m_tx_en[s] && !m_tx_sb[s];
          bit sbh = m_tx_en[s] && m_tx_sb[s];
          string rq = hit ? "R7" : (sbh ? "R9" : "R8");
          check_eq({tag, " ", rq}, $sformatf("txd_en pos%0d", j - 1), int'(bus_txd_en), int'(hit));
          check_eq({tag, " ", rq}, $sformatf("tx_take pos%0d", j - 1), int'(tx_take),
                   hit ? (1 << m_tx_ds[s]) : 0);
          check_eq({tag, " ", rq}, $sformatf("tx_strobe pos%0d", j - 1), int'(tx_strobe), int'(sbh));
          if (hit) check_eq({tag, " R7"}, $sformatf("txd pos%0d", j - 1),
                            int'(bus_txd === 1'b1), int'(ch_tx_bit[m_tx_ds[s]]));
        end else begin
          check_eq({tag, " R8"}, "txd_en idle", int'(bus_txd_en), 0);
          check_eq({tag, " R8"}, "tx_take idle", int'(tx_take), 0);
        end
      end
      if (!(skip_head && j <= 1)) begin
        if (j >= 2) begin
          int p = j - 2;
          int s = slot_for(fmt10, p);
          bit hit = m_rx_en[s] && !m_rx_sb[s];
          bit sbh = m_rx_en[s] && m_rx_sb[s];
          string rq = hit ? "R4" : (sbh ? "R6" : "R5");
          check_eq({tag, " ", rq}, $sformatf("rx_valid pos%0d", p), int'(rx_valid), int'(hit));
          check_eq({tag, " ", rq}, $sformatf("rx_strobe pos%0d", p), int'(rx_strobe), int'(sbh));
          if (hit) begin
            check_eq({tag, " R4"}, $sformatf("rx_bit pos%0d", p), int'(rx_bit), int'(pat[p]));
            check_eq({tag, " R4"}, $sformatf("rx_dest pos%0d", p), int'(rx_dest), int'(m_rx_ds[s]));
          end
        end else begin
          check_eq({tag, " R5"}, "rx_valid idle", int'(rx_valid), 0);
        end
      end
      bus_sync  = (j == 0);
      bus_rxd   = (j >= 1 && j <= 18) ? pat[j - 1] : 1'b0;
      ch_tx_bit = chd ^ 4'(j * 5);
    end
    bus_sync = 1'b0;
    bus_rxd  = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_quiet("R1 after reset");
  endtask

  task automatic cfg_dense;
    for (int s = 0; s < 18; s++) begin
      wr(1'b0, s, 1'b1, 1'b0, 2'(s % 4));
      wr(1'b1, s, 1'b1, 1'b0, 2'((s + 1) % 4));
    end
  endtask

  task automatic cfg_sparse;
    for (int s = 0; s < 18; s++) begin
      wr(1'b0, s, 1'b0, 1'b0, 2'd0);
      wr(1'b1, s, 1'b0, 1'b0, 2'd0);
    end
    wr(1'b0, 0, 1'b1, 1'b0, 2'd2);
    wr(1'b0, 1, 1'b1, 1'b0, 2'd2);
    wr(1'b0, 17, 1'b1, 1'b0, 2'd3);
    wr(1'b0, 16, 1'b1, 1'b1, 2'd0);
    for (int s = 8; s < 16; s++) wr(1'b1, s, 1'b1, 1'b1, 2'd0);
    wr(1'b1, 0, 1'b1, 1'b0, 2'd1);
    wr(1'b1, 17, 1'b1, 1'b0, 2'd0);
  endtask

  task automatic t_no_sync;  // R10 with full tables, R11 load
    cfg_dense();
    for (int j = 0; j < 25; j++) begin
      @(posedge clk); #1;
      check_quiet("R10 before first sync");
      bus_rxd = j[0] ^ j[2];
      ch_tx_bit = 4'(j);
    end
    bus_rxd = 1'b0;
  endtask

  task automatic t_dense_8;
    run_frame(1'b0, 18'h2B5A3, 4'b0110, 1'b0, "R11 dense fmt8");
    run_frame(1'b0, 18'h1C3F0, 4'b1001, 1'b0, "R2 dense fmt8 second frame");
  endtask

  task automatic t_dense_10;
    run_frame(1'b1, 18'h2B5A3, 4'b0110, 1'b0, "R3 dense fmt10");
  endtask

  task automatic t_sparse;
    cfg_sparse();
    run_frame(1'b1, 18'h3FFFF, 4'b1010, 1'b0, "R3 sparse fmt10");
    run_frame(1'b0, 18'h15555, 4'b0101, 1'b0, "R3 sparse fmt8");
  endtask

  task automatic t_resync;
    cfg_dense();
    fmt_10bit = 1'b0;
    for (int j = 0; j < 7; j++) begin
      @(posedge clk); #1;
      bus_sync = (j == 0);
      bus_rxd  = 1'b1;
    end
    run_frame(1'b0, 18'h0F0F3, 4'b0011, 1'b1, "R2 mid-frame resync");
    @(posedge clk); #1;
    check_quiet("R2 idle after frame");
  endtask

  initial begin
    fmt_10bit = 1'b0; bus_sync = 1'b0; bus_rxd = 1'b0;
    cfg_we = 1'b0; cfg_tx = 1'b0; cfg_slot = '0; cfg_en = 1'b0; cfg_strb = 1'b0; cfg_dest = '0;
    ch_tx_bit = '0;
    rst_n = 1'b0;
    t_reset();
    t_no_sync();
    t_dense_8();
    t_dense_10();
    t_sparse();
    t_resync();
    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_total++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

endmodule